// File: doc/BRIEF.md
# Status Register and Write-Protection Controller

This block owns the eight-bit status byte of a serial memory. The byte holds a status-lock bit, two protection-zone bits, the one-shot write-enable latch and the busy flag. The block takes already-decoded command strobes from the serial front end: enable, disable, status write and array write. For the two write commands it decides whether the command may start. On acceptance it raises a start pulse for the write timer and then holds busy until the timer reports that the cycle is done. A query port tells the front end whether any given address falls inside the currently locked zone.

The status-lock bit and the write-protect pin together form a hardware lock. While the lock bit is 1 and the pin is low, the protection bits cannot be rewritten. A status write stages its new values and commits them only when its cycle completes, so the old protection stays in force throughout the cycle.

Two resets exist. The asynchronous `rst_n` models first power-up and clears everything. The synchronous `soft_rst` models a later power cycle: it clears only the volatile bits and keeps the lock and protection bits.

Top module: `wpctl_status`

## Requirements
- R1: `status` reads {lock, 0, 0, 0, zone[1], zone[0], enable latch, busy} from bit 7 down to bit 0. `rst_n` low clears all eight bits.
- R2: An enable strobe sets the latch and a disable strobe clears it. If both arrive in one cycle, the disable wins. Both are ignored while busy is 1.
- R3: A status write or array write arriving while the enable latch is 0 is refused: no start pulse and no status change.
- R4: An accepted status write stages only data bits 7, 3 and 2. The other data bits have no effect. Lock and zone bits keep their old values until `cycle_done`, then take the staged ones.
- R5: While lock is 1 and `wp_n` is low, a status write is refused even with the latch set.
- R6: When lock is 0 or `wp_n` is high, a status write is accepted whenever the latch is 1 and busy is 0.
- R7: `addr_locked` reports the zone for a 14-bit address: zone 00 locks nothing; 01 locks 0x3000–0x3FFF; 10 locks 0x2000–0x3FFF; 11 locks the whole range.
- R8: An array write whose target page (the address with its low six bits cleared) lies in the locked zone is refused with no start pulse.
- R9: Busy reads 1 from the cycle after an accepted start until the edge where `cycle_done` is seen. That edge also clears the latch. `cycle_done` while idle has no effect.
- R10: Status and array writes are refused while busy. A strobe arriving in the same cycle as `cycle_done` is judged against the state before completion.
- R11: `soft_rst` clears the latch and busy, abandoning any staged status values. It keeps the lock and zone bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| soft_rst | input | 1 | Synchronous reset of the volatile bits |
| wp_n | input | 1 | Write-protect pin, low asserts protection |
| cmd_wren | input | 1 | Decoded enable-latch set strobe |
| cmd_wrdi | input | 1 | Decoded enable-latch clear strobe |
| cmd_wrsr | input | 1 | Decoded status-write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Decoded array-write strobe |
| wr_addr | input | 14 | Start address of the array write |
| cycle_done | input | 1 | Write timer completion pulse |
| chk_addr | input | 14 | Address queried against the locked zone |
| status | output | 8 | Status byte |
| wr_ok | output | 1 | Latch set and not busy |
| addr_locked | output | 1 | `chk_addr` lies in the locked zone |
| wrsr_start | output | 1 | Accepted status write; starts the timer |
| write_start | output | 1 | Accepted array write; starts the timer |

## Verification
The completion of a timed cycle can land in the same cycle as a new command strobe. The bench provokes this by raising `cycle_done` together with an enable strobe, and separately together with a status-write strobe. Both strobes must be judged against the still-busy state. The enable is therefore dropped and the latch ends at 0, and the status write produces no start pulse and leaves the byte at its completed value.

// File: rtl/wpctl_pkg.sv
package wpctl_pkg;

  typedef struct packed {
    logic       lock;
    logic [1:0] zone;
  } nv_bits_t;

  typedef enum logic {
    CYC_ARRAY  = 1'b0,
    CYC_STATUS = 1'b1
  } cyc_kind_t;

  // Zone decode on the two most significant address bits.
  function automatic logic zone_hit(input logic [1:0] zone, input logic [1:0] top2);
    logic hit;
    case (zone)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

  function automatic logic [7:0] pack_status(input nv_bits_t nv, input logic wel, input logic wip);
    return {nv.lock, 3'b000, nv.zone, wel, wip};
  endfunction

  function automatic nv_bits_t stage_from(input logic [7:0] d);
    nv_bits_t n;
    n.lock = d[7];
    n.zone = d[3:2];
    return n;
  endfunction

endpackage

// File: rtl/wpctl_zone.sv
module wpctl_zone
  import wpctl_pkg::*;
#(
  parameter int AW = 14,
  parameter int PW = 6
) (
  input  logic [1:0]    zone,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] PAGE_MASK = ~((AW'(1) << PW) - AW'(1));

  logic [AW-1:0] page_base;

  always_comb begin
    page_base = addr & PAGE_MASK;
    hit       = zone_hit(zone, page_base[AW-1 -: 2]);
  end
endmodule

// File: rtl/wpctl_gate.sv
module wpctl_gate (
  input  logic wel,
  input  logic wip,
  input  logic lock,
  input  logic wp_n,
  input  logic cmd_wrsr,
  input  logic cmd_write,
  input  logic wr_hit,
  output logic hpm,
  output logic wrsr_go,
  output logic write_go
);
  logic armed;

  always_comb begin
    armed    = wel & ~wip;
    hpm      = lock & ~wp_n;
    wrsr_go  = cmd_wrsr & armed & ~hpm;
    write_go = cmd_write & armed & ~wr_hit & ~cmd_wrsr;
  end
endmodule

// File: rtl/wpctl_regs.sv
module wpctl_regs
  import wpctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       cmd_wren,
  input  logic       cmd_wrdi,
  input  logic       wrsr_go,
  input  logic       write_go,
  input  logic [7:0] wrsr_data,
  input  logic       cycle_done,
  output nv_bits_t   nv_q,
  output logic       wel_q,
  output logic       wip_q,
  output logic       evt_done
);
  nv_bits_t  pend_q;
  cyc_kind_t kind_q;

  assign evt_done = wip_q & cycle_done & ~soft_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= '0;
      pend_q <= '0;
      kind_q <= CYC_ARRAY;
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
    end else if (soft_rst) begin
      wel_q <= 1'b0;
      wip_q <= 1'b0;
    end else if (wip_q) begin
      if (cycle_done) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
        if (kind_q == CYC_STATUS) nv_q <= pend_q;
      end
    end else begin
      if (wrsr_go) begin
        wip_q  <= 1'b1;
        kind_q <= CYC_STATUS;
        pend_q <= stage_from(wrsr_data);
      end else if (write_go) begin
        wip_q  <= 1'b1;
        kind_q <= CYC_ARRAY;
      end
      if (cmd_wrdi)      wel_q <= 1'b0;
      else if (cmd_wren) wel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wpctl_status.sv
module wpctl_status
  import wpctl_pkg::*;
#(
  parameter int AW = 14,
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wp_n,
  input  logic          cmd_wren,
  input  logic          cmd_wrdi,
  input  logic          cmd_wrsr,
  input  logic [7:0]    wrsr_data,
  input  logic          cmd_write,
  input  logic [AW-1:0] wr_addr,
  input  logic          cycle_done,
  input  logic [AW-1:0] chk_addr,
  output logic [7:0]    status,
  output logic          wr_ok,
  output logic          addr_locked,
  output logic          wrsr_start,
  output logic          write_start
);
  localparam int NZ = 2;

  nv_bits_t      nv;
  logic          wel, wip, hpm, wr_hit, evt_done;
  logic          wrsr_go, write_go;
  logic [AW-1:0] zaddr [NZ];
  logic [NZ-1:0] zhit;

  assign zaddr[0] = chk_addr;
  assign zaddr[1] = wr_addr;

  for (genvar gi = 0; gi < NZ; gi++) begin : g_zone
    wpctl_zone #(.AW(AW), .PW(PW)) u_zone (
      .zone (nv.zone),
      .addr (zaddr[gi]),
      .hit  (zhit[gi])
    );
  end

  assign addr_locked = zhit[0];
  assign wr_hit      = zhit[1];

  wpctl_gate u_gate (
    .wel       (wel),
    .wip       (wip),
    .lock      (nv.lock),
    .wp_n      (wp_n),
    .cmd_wrsr  (cmd_wrsr),
    .cmd_write (cmd_write),
    .wr_hit    (wr_hit),
    .hpm       (hpm),
    .wrsr_go   (wrsr_go),
    .write_go  (write_go)
  );

  wpctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .wrsr_go    (wrsr_go),
    .write_go   (write_go),
    .wrsr_data  (wrsr_data),
    .cycle_done (cycle_done),
    .nv_q       (nv),
    .wel_q      (wel),
    .wip_q      (wip),
    .evt_done   (evt_done)
  );

  assign status      = pack_status(nv, wel, wip);
  assign wr_ok       = wel & ~wip;
  assign wrsr_start  = wrsr_go & ~soft_rst;
  assign write_start = write_go & ~soft_rst;
endmodule

// File: rtl/wpctl_status_chk.sv
module wpctl_status_chk #(
  parameter int AW = 14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       wp_n,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cycle_done,
  input logic [7:0] status,
  input logic       wrsr_start,
  input logic       write_start,
  input logic       wr_hit,
  input logic       hpm,
  input logic       evt_done
);
  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !cmd_wrdi && !status[0] && !soft_rst) |=> status[1]);

  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrdi && !status[0]) |=> !status[1]);

  a_r3_start_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_start || write_start) |-> status[1]);

  a_r4_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_done |=> $stable(status[7:2]));

  a_r5_lock_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !wp_n) |-> !wrsr_start);

  a_r8_zone_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |-> !write_start);

  a_r9_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrsr_start || write_start) && !soft_rst) |=> status[0]);

  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && cycle_done && !soft_rst) |=> (!status[0] && !status[1]));

  a_r10_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !(wrsr_start || write_start));

  a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status[1:0] == 2'b00));

  a_r5_hpm_matches_pins: assert property (@(posedge clk) disable iff (!rst_n)
    hpm |-> (status[7] && !wp_n));
endmodule

bind wpctl_status wpctl_status_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .wp_n        (wp_n),
  .cmd_wren    (cmd_wren),
  .cmd_wrdi    (cmd_wrdi),
  .cycle_done  (cycle_done),
  .status      (status),
  .wrsr_start  (wrsr_start),
  .write_start (write_start),
  .wr_hit      (wr_hit),
  .hpm         (hpm),
  .evt_done    (evt_done)
);

// File: tb/wpctl_status_tb_top.sv
module wpctl_status_tb_top;
  localparam int T  = 10;
  localparam int AW = 14;
  localparam int NV = 25;

  // vector: op[34:32] wp_n[31] data[30:23] addr[22:9] exp_start[8] exp_status[7:0]
  // op: 0 idle, 1 enable, 2 disable, 3 status write, 4 array write, 5 cycle done
  localparam logic [34:0] VEC [NV] = '{
    {3'd3, 1'b1, 8'h8C, 14'h0000, 1'b0, 8'h00},  // R3
    {3'd4, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h00},  // R3
    {3'd1, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h02},  // R2
    {3'd2, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h00},  // R2
    {3'd1, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h02},
    {3'd3, 1'b1, 8'hFF, 14'h0000, 1'b1, 8'h03},  // R4 R6
    {3'd1, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h03},  // R2 busy
    {3'd3, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h03},  // R10
    {3'd5, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h8C},  // R4 R9
    {3'd1, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h8E},
    {3'd4, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h8E},  // R8
    {3'd0, 1'b0, 8'h00, 14'h0000, 1'b0, 8'h8E},
    {3'd3, 1'b0, 8'h00, 14'h0000, 1'b0, 8'h8E},  // R5
    {3'd3, 1'b1, 8'h84, 14'h0000, 1'b1, 8'h8F},  // R6
    {3'd5, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h84},
    {3'd1, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h86},
    {3'd4, 1'b1, 8'h00, 14'h2FFF, 1'b1, 8'h87},  // R8
    {3'd5, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h84},  // R9
    {3'd1, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h86},
    {3'd4, 1'b1, 8'h00, 14'h3000, 1'b0, 8'h86},  // R8
    {3'd3, 1'b1, 8'h08, 14'h0000, 1'b1, 8'h87},
    {3'd5, 1'b1, 8'h00, 14'h0000, 1'b0, 8'h08},
    {3'd1, 1'b0, 8'h00, 14'h0000, 1'b0, 8'h0A},
    {3'd3, 1'b0, 8'h00, 14'h0000, 1'b1, 8'h0B},  // R6
    {3'd5, 1'b0, 8'h00, 14'h0000, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, wp_n = 1'b1;
  logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_write = 1'b0, cycle_done = 1'b0;
  logic [7:0] wrsr_data = '0;
  logic [AW-1:0] wr_addr = '0, chk_addr = '0;
  logic [7:0] status;
  logic wr_ok, addr_locked, wrsr_start, write_start;
  int n_chk = 0, n_fail = 0;
  logic acc;

  always #(T/2) clk = ~clk;

  wpctl_status #(.AW(AW)) dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic dis, input logic sw, input logic aw,
                      input logic dn, input logic [7:0] d, input logic [AW-1:0] a,
                      output logic started);
    @(negedge clk);
    cmd_wren = en; cmd_wrdi = dis; cmd_wrsr = sw; cmd_write = aw; cycle_done = dn;
    wrsr_data = d; wr_addr = a;
    #1 started = wrsr_start | write_start;
    @(posedge clk);
    #1;
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0; cycle_done = 0;
  endtask

  task automatic set_zone(input logic [1:0] z);
    logic s;
    step(1, 0, 0, 0, 0, 8'h00, '0, s);
    step(0, 0, 1, 0, 0, {6'b0, z} << 2, '0, s);
    step(0, 0, 0, 0, 1, 8'h00, '0, s);
  endtask

  function automatic logic exp_lock(input logic [1:0] z, input int addr);
    case (z)
      2'd0: return 1'b0;
      2'd1: return addr >= 'h3000;
      2'd2: return addr >= 'h2000;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #(T * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [34:0] v;
    int addrs [5] = '{'h0000, 'h1FFF, 'h2000, 'h2FFF, 'h3FFF};
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R7 reset lock", {7'b0, addr_locked}, 8'h00);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wp_n = v[31];
      step(v[34:32] == 3'd1, v[34:32] == 3'd2, v[34:32] == 3'd3, v[34:32] == 3'd4,
           v[34:32] == 3'd5, v[30:23], v[22:9], acc);
      chk($sformatf("vector %0d start", i), {7'b0, acc}, {7'b0, v[8]});
      chk($sformatf("vector %0d status", i), status, v[7:0]);
    end
    wp_n = 1'b1;

    // R7 zone query for every zone value
    for (int z = 0; z < 4; z++) begin
      set_zone(z[1:0]);
      for (int k = 0; k < 5; k++) begin
        chk_addr = addrs[k][AW-1:0];
        #1 chk($sformatf("R7 zone %0d addr %h", z, addrs[k]), {7'b0, addr_locked},
               {7'b0, exp_lock(z[1:0], addrs[k])});
      end
    end

    // R11 soft reset keeps the zone bits (zone 11 now)
    step(1, 0, 0, 0, 0, 0, '0, acc);
    chk("R11 latch before soft reset", status, 8'h0E);
    @(negedge clk); soft_rst = 1; @(posedge clk); #1 soft_rst = 0;
    chk("R11 soft reset", status, 8'h0C);
    // R11 staged value abandoned; R9 idle done ignored
    step(1, 0, 0, 0, 0, 0, '0, acc);
    step(0, 0, 1, 0, 0, 8'h80, '0, acc);
    chk("R11 pending", status, 8'h0F);
    @(negedge clk); soft_rst = 1; @(posedge clk); #1 soft_rst = 0;
    step(0, 0, 0, 0, 1, 0, '0, acc);
    chk("R11 R9 abandoned cycle", status, 8'h0C);

    // R2 disable wins over enable
    step(1, 1, 0, 0, 0, 0, '0, acc);
    chk("R2 both strobes", status, 8'h0C);

    // R10 completion and enable in the same cycle
    set_zone(2'b00);
    step(1, 0, 0, 0, 0, 0, '0, acc);
    step(0, 0, 0, 1, 0, 0, 14'h0100, acc);
    chk("R9 array write busy", status, 8'h03);
    step(1, 0, 0, 0, 1, 0, '0, acc);
    chk("R10 done with enable", status, 8'h00);
    // R10 completion and status write in the same cycle
    step(1, 0, 0, 0, 0, 0, '0, acc);
    step(0, 0, 0, 1, 0, 0, 14'h0100, acc);
    step(0, 0, 1, 0, 1, 8'h8C, '0, acc);
    chk("R10 done with status write start", {7'b0, acc}, 8'h00);
    chk("R10 done with status write", status, 8'h00);

    // R1 hard reset clears the nonvolatile bits too
    set_zone(2'b11);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 hard reset", status, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule